// File: doc/BRIEF.md
# Eight-Channel Block Transfer Engine

This engine copies bytes between a 24-bit wide bus and a register bus that is addressed as a fixed base (0x2100) plus an 8-bit offset. Eight channels each hold their own small set of configuration bytes. Writing a non-zero channel mask to the trigger port starts a run. The engine serves the channels in the mask from the lowest index to the highest, and it finishes each one before it starts the next.

Each channel moves one byte per clock cycle. The source address is 16 bits wide and can count up, count down or stay fixed. It always wraps inside its bank, and the bank byte supplies the upper address bits unchanged. The register-bus target follows a repeating lane pattern of one to four offsets, chosen by the mode byte. The length counter can run out partway through a pattern cycle. When a channel finishes, its source address registers hold the address the engine stopped at, and its length registers read zero. Memory and register models sit behind plain byte ports. The engine only supplies addresses and strobes, and it routes the read data to the write side.

Top module: `gpdma_engine`

## Requirements
- R1: The channels whose bits are set in the trigger mask run in ascending index order. Each channel completes all of its beats before the next channel issues its first beat.
- R2: The step is chosen by mode bit 3 and mode bit 4. Mode bit 3 set keeps the source address fixed, whatever bit 4 holds. Otherwise bit 4 set steps the address by -1 after each beat, and bit 4 clear steps it by +1.
- R3: A length of 0x0000 transfers 65536 bytes. Any other length transfers exactly that many bytes.
- R4: The wide-bus address is {bank, source[15:0]}. The 16-bit source wraps (0xFFFF+1 gives 0x0000, 0x0000-1 gives 0xFFFF), and the bank bits never change during a transfer.
- R5: The register-bus address is 0x2100 + offset + lane. The lane for beat k comes from mode bits 2:0:
  - kinds 0, 2 and 6 always use lane 0;
  - kinds 1 and 5 use k mod 2;
  - kinds 3 and 7 use (k/2) mod 2;
  - kind 4 uses k mod 4.
  The transfer stops mid-pattern when the length runs out.
- R6: Mode bit 7 clear reads the wide bus and writes the register bus. Mode bit 7 set reads the register bus and writes the wide bus. The byte read is presented unchanged as the write data in the same cycle.
- R7: On completion the channel's source bytes (offset 2 low, offset 3 high) hold the source address after the last step. Its length bytes (offset 5 low, offset 6 high) read 0x00.
- R8: The configuration port is addressed as {channel[2:0], offset[3:0]}. Offsets 0x0 to 0xB are read/write bytes that return the value last written, and they reset to 0x00. The layout is: 0 mode, 1 register offset, 2/3 source low/high, 4 bank, 5/6 length low/high, 7 to B general bytes. Offsets 0xC to 0xF read 0x00.
- R9: From the cycle after a trigger write until completion, the trigger readback shows the channels still pending and busy is high. A trigger write while busy has no effect. Once all channels are done, the readback is 0x00 and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 7 | Channel (bits 6:4) and offset (bits 3:0) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| trig_we | input | 1 | Trigger mask write strobe |
| trig_wdata | input | 8 | Channel mask to run |
| trig_rdata | output | 8 | Channels still pending |
| busy | output | 1 | Engine active |
| wide_addr | output | 24 | Wide-bus byte address |
| wide_re | output | 1 | Wide-bus read strobe |
| wide_we | output | 1 | Wide-bus write strobe |
| wide_wdata | output | 8 | Wide-bus write data |
| wide_rdata | input | 8 | Wide-bus read data |
| reg_addr | output | 16 | Register-bus address |
| reg_re | output | 1 | Register-bus read strobe |
| reg_we | output | 1 | Register-bus write strobe |
| reg_wdata | output | 8 | Register-bus write data |
| reg_rdata | input | 8 | Register-bus read data |

## Verification
The stimulus covers several cases:
- a short incrementing transfer that starts at 0xFFFE, which shows the in-bank wrap and a pair pattern cut off after its first lane;
- a two-channel mask that combines the double-pair and the four-lane patterns, which shows the service order and a cut-off mid-pattern;
- a mix of decrementing, fixed, and fixed-with-down-bit channels, which separates the three step choices;
- a reverse-direction transfer with a trigger write while busy;
- a zero-length fixed-address channel, which shows the 65536-byte count.

Each beat is compared in order against addresses and data predicted from the written configuration. The register readback after each run checks the final address and the cleared length.

// File: rtl/gpdma_pkg.sv
package gpdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_LOAD,
    ST_MOVE,
    ST_WB
  } eng_state_t;

  localparam int NREG     = 12;
  localparam int OFS_MODE = 0;
  localparam int OFS_DOFF = 1;
  localparam int OFS_SRCL = 2;
  localparam int OFS_SRCH = 3;
  localparam int OFS_BANK = 4;
  localparam int OFS_LENL = 5;
  localparam int OFS_LENH = 6;

  // lane offset for a beat, from the pattern kind and the beat phase
  function automatic logic [1:0] lane_of(input logic [2:0] kind, input logic [1:0] phase);
    case (kind)
      3'd1, 3'd5: return {1'b0, phase[0]};
      3'd3, 3'd7: return {1'b0, phase[1]};
      3'd4:       return phase;
      default:    return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/gpdma_regfile.sv
module gpdma_regfile
  import gpdma_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CH_W   = 3,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [CH_W-1:0]   host_ch,
  input  logic [3:0]        host_reg,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [CH_W-1:0]   sel_ch,
  output logic [7:0]        sel_mode,
  output logic [7:0]        sel_doff,
  output logic [ADDR_W-1:0] sel_src,
  output logic [7:0]        sel_bank,
  output logic [ADDR_W-1:0] sel_len,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_src
);

  localparam int TOT = NCH * NREG;

  logic [TOT*8-1:0] rf_flat;

  for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
    for (genvar gr = 0; gr < NREG; gr++) begin : g_r
      localparam bit ENG_OWNED = (gr == OFS_SRCL) || (gr == OFS_SRCH) ||
                                 (gr == OFS_LENL) || (gr == OFS_LENH);
      logic [7:0] q;
      logic [7:0] d;
      logic       hit_h;
      logic       hit_e;

      always_comb begin
        hit_h = host_we && (host_ch == CH_W'(gc)) && (host_reg == 4'(gr));
        hit_e = ENG_OWNED && wb_en && (sel_ch == CH_W'(gc));
        d     = q;
        if (hit_h) d = host_wdata;
        if (hit_e) begin
          if (gr == OFS_SRCL)      d = wb_src[7:0];
          else if (gr == OFS_SRCH) d = wb_src[15:8];
          else                     d = 8'h00;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               q <= 8'h00;
        else if (hit_h || hit_e)  q <= d;
      end

      assign rf_flat[(gc*NREG+gr)*8 +: 8] = q;
    end
  end

  always_comb begin
    int hidx;
    int sidx;
    hidx = int'(host_ch) * NREG + int'(host_reg);
    sidx = int'(sel_ch) * NREG;
    if (int'(host_reg) < NREG) host_rdata = rf_flat[hidx*8 +: 8];
    else                       host_rdata = 8'h00;
    sel_mode = rf_flat[(sidx+OFS_MODE)*8 +: 8];
    sel_doff = rf_flat[(sidx+OFS_DOFF)*8 +: 8];
    sel_bank = rf_flat[(sidx+OFS_BANK)*8 +: 8];
    sel_src  = {rf_flat[(sidx+OFS_SRCH)*8 +: 8], rf_flat[(sidx+OFS_SRCL)*8 +: 8]};
    sel_len  = {rf_flat[(sidx+OFS_LENH)*8 +: 8], rf_flat[(sidx+OFS_LENL)*8 +: 8]};
  end

  // a host write to a read/write offset is visible next cycle unless the engine owns it then
  AST_HOST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_reg == 4'd0 && !wb_en) |=> (sel_ch != $past(host_ch)) || (sel_mode == $past(host_wdata))) // R8
    else $error("mode byte write lost");

endmodule

// File: rtl/gpdma_pick.sv
module gpdma_pick #(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic [NCH-1:0]  mask,
  output logic [CH_W-1:0] idx,
  output logic            any
);

  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) idx = CH_W'(i);
    end
    any = |mask;
  end

endmodule

// File: rtl/gpdma_stepper.sv
module gpdma_stepper
  import gpdma_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          BANK_W   = 8,
  parameter logic [15:0] REG_BASE = 16'h2100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     adv,
  input  logic                     ld_dir,
  input  logic                     ld_fixed,
  input  logic                     ld_down,
  input  logic [2:0]               ld_kind,
  input  logic [7:0]               ld_doff,
  input  logic [ADDR_W-1:0]        ld_src,
  input  logic [BANK_W-1:0]        ld_bank,
  input  logic [ADDR_W-1:0]        ld_len,
  output logic [BANK_W+ADDR_W-1:0] wide_addr,
  output logic [15:0]              reg_addr,
  output logic                     dir,
  output logic                     last,
  output logic [ADDR_W-1:0]        cur_src
);

  localparam int CNT_W = ADDR_W + 1;

  logic              dir_q, dir_d;
  logic              fixed_q, fixed_d;
  logic              down_q, down_d;
  logic [2:0]        kind_q, kind_d;
  logic [7:0]        doff_q, doff_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [1:0]        phase_q, phase_d;
  logic [ADDR_W-1:0] step;

  always_comb begin
    if (fixed_q)     step = '0;
    else if (down_q) step = '1;
    else             step = ADDR_W'(1);
  end

  always_comb begin
    dir_d    = dir_q;
    fixed_d  = fixed_q;
    down_d   = down_q;
    kind_d   = kind_q;
    doff_d   = doff_q;
    bank_d   = bank_q;
    src_d    = src_q;
    remain_d = remain_q;
    phase_d  = phase_q;
    if (load) begin
      dir_d    = ld_dir;
      fixed_d  = ld_fixed;
      down_d   = ld_down;
      kind_d   = ld_kind;
      doff_d   = ld_doff;
      bank_d   = ld_bank;
      src_d    = ld_src;
      remain_d = (ld_len == '0) ? (CNT_W'(1) << ADDR_W) : {1'b0, ld_len};
      phase_d  = 2'd0;
    end else if (adv) begin
      src_d    = src_q + step;
      remain_d = remain_q - CNT_W'(1);
      phase_d  = phase_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= 1'b0;
      fixed_q  <= 1'b0;
      down_q   <= 1'b0;
      kind_q   <= 3'd0;
      doff_q   <= 8'h00;
      bank_q   <= '0;
      src_q    <= '0;
      remain_q <= '0;
      phase_q  <= 2'd0;
    end else if (load || adv) begin
      dir_q    <= dir_d;
      fixed_q  <= fixed_d;
      down_q   <= down_d;
      kind_q   <= kind_d;
      doff_q   <= doff_d;
      bank_q   <= bank_d;
      src_q    <= src_d;
      remain_q <= remain_d;
      phase_q  <= phase_d;
    end
  end

  assign wide_addr = {bank_q, src_q};
  assign reg_addr  = REG_BASE + {8'h00, doff_q} + {14'd0, lane_of(kind_q, phase_q)};
  assign dir       = dir_q;
  assign last      = (remain_q == CNT_W'(1));
  assign cur_src   = src_q;

  AST_FIXED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && fixed_q) |=> (wide_addr == $past(wide_addr))) // R2
    else $error("fixed address moved");

  AST_BANK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (wide_addr[BANK_W+ADDR_W-1:ADDR_W] == $past(wide_addr[BANK_W+ADDR_W-1:ADDR_W]))) // R4
    else $error("bank changed mid transfer");

  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (remain_q != '0)) // R3
    else $error("beat issued with no bytes left");

endmodule

// File: rtl/gpdma_engine.sv
module gpdma_engine
  import gpdma_pkg::*;
#(
  parameter int          NCH      = 8,
  parameter int          ADDR_W   = 16,
  parameter int          BANK_W   = 8,
  parameter logic [15:0] REG_BASE = 16'h2100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(NCH)+3:0]     cfg_addr,
  input  logic [7:0]                 cfg_wdata,
  output logic [7:0]                 cfg_rdata,
  input  logic                       trig_we,
  input  logic [NCH-1:0]             trig_wdata,
  output logic [NCH-1:0]             trig_rdata,
  output logic                       busy,
  output logic [BANK_W+ADDR_W-1:0]   wide_addr,
  output logic                       wide_re,
  output logic                       wide_we,
  output logic [7:0]                 wide_wdata,
  input  logic [7:0]                 wide_rdata,
  output logic [15:0]                reg_addr,
  output logic                       reg_re,
  output logic                       reg_we,
  output logic [7:0]                 reg_wdata,
  input  logic [7:0]                 reg_rdata
);

  localparam int CH_W = $clog2(NCH);

  // reset: asserted at once, released on a clock edge
  logic rst_m1, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_m1 <= 1'b1;
      rst_s  <= rst_m1;
    end
  end

  eng_state_t        state_q, state_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [NCH-1:0]    pend_q, pend_d;
  logic              load, adv, wb_en;

  logic [7:0]        sel_mode, sel_doff, sel_bank;
  logic [ADDR_W-1:0] sel_src, sel_len, cur_src;
  logic [CH_W-1:0]   pick_idx;
  logic              pick_any;
  logic              step_last, step_dir;
  logic              beat;
  logic [NCH-1:0]    below_mask;
  logic              unused_mode;

  assign unused_mode = ^sel_mode[6:5];

  gpdma_regfile #(.NCH(NCH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_s),
    .host_we    (cfg_we),
    .host_ch    (cfg_addr[CH_W+3:4]),
    .host_reg   (cfg_addr[3:0]),
    .host_wdata (cfg_wdata),
    .host_rdata (cfg_rdata),
    .sel_ch     (ch_q),
    .sel_mode   (sel_mode),
    .sel_doff   (sel_doff),
    .sel_src    (sel_src),
    .sel_bank   (sel_bank),
    .sel_len    (sel_len),
    .wb_en      (wb_en),
    .wb_src     (cur_src)
  );

  gpdma_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
    .mask (pend_q),
    .idx  (pick_idx),
    .any  (pick_any)
  );

  gpdma_stepper #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_BASE(REG_BASE)) u_step (
    .clk       (clk),
    .rst_n     (rst_s),
    .load      (load),
    .adv       (adv),
    .ld_dir    (sel_mode[7]),
    .ld_fixed  (sel_mode[3]),
    .ld_down   (sel_mode[4]),
    .ld_kind   (sel_mode[2:0]),
    .ld_doff   (sel_doff),
    .ld_src    (sel_src),
    .ld_bank   (sel_bank[BANK_W-1:0]),
    .ld_len    (sel_len),
    .wide_addr (wide_addr),
    .reg_addr  (reg_addr),
    .dir       (step_dir),
    .last      (step_last),
    .cur_src   (cur_src)
  );

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    pend_d  = pend_q;
    load    = 1'b0;
    adv     = 1'b0;
    wb_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (trig_we && (trig_wdata != '0)) begin
          pend_d  = trig_wdata;
          state_d = ST_SEL;
        end
      end
      ST_SEL: begin
        if (pick_any) begin
          ch_d    = pick_idx;
          state_d = ST_LOAD;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_LOAD: begin
        load    = 1'b1;
        state_d = ST_MOVE;
      end
      ST_MOVE: begin
        adv = 1'b1;
        if (step_last) state_d = ST_WB;
      end
      ST_WB: begin
        wb_en   = 1'b1;
        pend_d  = pend_q & ~(NCH'(1) << ch_q);
        state_d = ST_SEL;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      pend_q  <= pend_d;
    end
  end

  assign beat       = (state_q == ST_MOVE);
  assign wide_re    = beat && !step_dir;
  assign reg_we     = beat && !step_dir;
  assign wide_we    = beat && step_dir;
  assign reg_re     = beat && step_dir;
  assign reg_wdata  = wide_rdata;
  assign wide_wdata = reg_rdata;
  assign trig_rdata = pend_q;
  assign busy       = (state_q != ST_IDLE);
  assign below_mask = (NCH'(1) << ch_q) - NCH'(1);

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_s)
    beat |-> (((pend_q & below_mask) == '0) && pend_q[ch_q])) // R1
    else $error("channel served out of order");

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_s)
    beat |-> ($onehot({wide_re, wide_we}) && $onehot({reg_re, reg_we}))) // R6
    else $error("strobe pairing broken");

  AST_LEN_CLEARED: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_WB) |=> (sel_len == '0)) // R7
    else $error("length not cleared");

  AST_SRC_WRITTEN: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_WB) |=> (sel_src == $past(cur_src))) // R7
    else $error("final source not stored");

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_IDLE) |-> (pend_q == '0)) // R9
    else $error("pending bits while idle");

  AST_NO_NEW_WORK: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q != ST_IDLE) |=> ((pend_q & ~$past(pend_q)) == '0)) // R9
    else $error("trigger accepted while busy");

endmodule

// File: tb/gpdma_engine_bench.sv
module gpdma_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [6:0]  cfg_addr;
  logic [7:0]  cfg_wdata, cfg_rdata;
  logic        trig_we;
  logic [7:0]  trig_wdata, trig_rdata;
  logic        busy;
  logic [23:0] wide_addr;
  logic        wide_re, wide_we;
  logic [7:0]  wide_wdata, wide_rdata;
  logic [15:0] reg_addr;
  logic        reg_re, reg_we;
  logic [7:0]  reg_wdata, reg_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  // byte models behind the two buses
  function automatic logic [7:0] wmem(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] rmem(input logic [15:0] a);
    return a[7:0] + 8'h11;
  endfunction
  assign wide_rdata = wmem(wide_addr);
  assign reg_rdata  = rmem(reg_addr);

  gpdma_engine u_gpdma_engine (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .trig_rdata(trig_rdata), .busy(busy),
    .wide_addr(wide_addr), .wide_re(wide_re), .wide_we(wide_we),
    .wide_wdata(wide_wdata), .wide_rdata(wide_rdata),
    .reg_addr(reg_addr), .reg_re(reg_re), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  typedef struct packed {
    logic        dir;
    logic [23:0] wa;
    logic [15:0] ra;
  } beat_t;

  beat_t       expq[$];
  logic [7:0]  model [8][12];
  int          checks = 0;
  int          errors = 0;
  string       cur_tag = "R1";
  bit          mon_on = 1'b0;
  bit          done = 1'b0;

  task automatic note(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: every beat is popped and compared in order
  always @(negedge clk) begin
    if (mon_on && (wide_re || wide_we)) begin
      if (expq.size() == 0) begin
        note(1'b0, cur_tag, "unexpected beat at wide address", {8'h0, wide_addr}, 32'h0);
      end else begin
        beat_t e;
        e = expq.pop_front();
        note(wide_addr == e.wa, cur_tag, "wide address (R4)", {8'h0, wide_addr}, {8'h0, e.wa});
        note(reg_addr == e.ra, cur_tag, "register address (R5)", {16'h0, reg_addr}, {16'h0, e.ra});
        note(wide_we == e.dir && reg_re == e.dir, cur_tag, "direction (R6)",
             {30'h0, wide_we, reg_re}, {30'h0, e.dir, e.dir});
        if (e.dir) note(wide_wdata == rmem(e.ra), cur_tag, "data to wide bus (R6)",
                        {24'h0, wide_wdata}, {24'h0, rmem(e.ra)});
        else       note(reg_wdata == wmem(e.wa), cur_tag, "data to register bus (R6)",
                        {24'h0, reg_wdata}, {24'h0, wmem(e.wa)});
      end
    end
  end

  // watchdog
  initial begin
    for (int n = 0; n < LIMIT; n++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end within %0d cycles", LIMIT);
    finish_up();
  end

  task automatic wr(input int c, input int r, input logic [7:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = {3'(c), 4'(r)};
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (r < 12) model[c][r] = v;
  endtask

  task automatic rd_check(input int c, input int r, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = {3'(c), 4'(r)};
    #1;
    note(cfg_rdata == exp, tag, $sformatf("config ch%0d ofs%0h", c, r),
         {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  task automatic setup(input int c, input logic [7:0] mode, input logic [7:0] off,
                       input logic [15:0] src, input logic [7:0] bank, input logic [15:0] len);
    wr(c, 0, mode);
    wr(c, 1, off);
    wr(c, 2, src[7:0]);
    wr(c, 3, src[15:8]);
    wr(c, 4, bank);
    wr(c, 5, len[7:0]);
    wr(c, 6, len[15:8]);
  endtask

  // driver: predicts every beat of a channel and the registers it leaves behind
  task automatic predict(input int c);
    logic [7:0]  mode;
    logic [15:0] src;
    int          n;
    int          lane;
    mode = model[c][0];
    src  = {model[c][3], model[c][2]};
    n    = ({model[c][6], model[c][5]} == 16'h0) ? 65536 : int'({model[c][6], model[c][5]});
    for (int k = 0; k < n; k++) begin
      beat_t b;
      case (mode[2:0])
        3'd1, 3'd5: lane = k % 2;
        3'd3, 3'd7: lane = (k / 2) % 2;
        3'd4:       lane = k % 4;
        default:    lane = 0;
      endcase
      b.dir = mode[7];
      b.wa  = {model[c][4], src};
      b.ra  = 16'h2100 + {8'h00, model[c][1]} + 16'(lane);
      expq.push_back(b);
      if (!mode[3]) src = mode[4] ? src - 16'd1 : src + 16'd1;
    end
    model[c][2] = src[7:0];
    model[c][3] = src[15:8];
    model[c][5] = 8'h00;
    model[c][6] = 8'h00;
  endtask

  task automatic run(input logic [7:0] mask, input string tag, input bit poke);
    cur_tag = tag;
    for (int c = 0; c < 8; c++) if (mask[c]) predict(c);
    @(negedge clk);
    trig_we    = 1'b1;
    trig_wdata = mask;
    @(negedge clk);
    trig_we = 1'b0;
    note(busy == 1'b1, "R9", "busy after trigger", {31'h0, busy}, 32'h1);
    note(trig_rdata == mask, "R9", "pending readback", {24'h0, trig_rdata}, {24'h0, mask});
    if (poke) begin
      trig_we    = 1'b1;
      trig_wdata = 8'hFF;
      @(negedge clk);
      trig_we = 1'b0;
      note(trig_rdata == mask, "R9", "trigger ignored while busy", {24'h0, trig_rdata}, {24'h0, mask});
    end
    while (busy) @(negedge clk);
    note(expq.size() == 0, tag, "beats left unissued (R1)", expq.size(), 32'h0);
    expq.delete();
    note(trig_rdata == 8'h00, "R9", "trigger readback after completion", {24'h0, trig_rdata}, 32'h0);
    for (int c = 0; c < 8; c++) begin
      if (mask[c]) begin
        rd_check(c, 2, model[c][2], "R7");
        rd_check(c, 3, model[c][3], "R7");
        rd_check(c, 5, 8'h00, "R7");
        rd_check(c, 6, 8'h00, "R7");
      end
    end
  endtask

  initial begin
    rst_n      = 1'b0;
    cfg_we     = 1'b0;
    cfg_addr   = '0;
    cfg_wdata  = '0;
    trig_we    = 1'b0;
    trig_wdata = '0;
    for (int c = 0; c < 8; c++) for (int r = 0; r < 12; r++) model[c][r] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    // reset state
    note(busy == 1'b0, "R9", "busy after reset", {31'h0, busy}, 32'h0);
    note(trig_rdata == 8'h00, "R9", "trigger readback after reset", {24'h0, trig_rdata}, 32'h0);
    note(!(wide_re || wide_we || reg_re || reg_we), "R6", "strobes after reset",
         {28'h0, wide_re, wide_we, reg_re, reg_we}, 32'h0);
    rd_check(3, 0, 8'h00, "R8");

    // R8: every byte offset of one channel, plus an unmapped offset
    for (int r = 0; r < 12; r++) wr(7, r, 8'(r * 16 + 8'hA5));
    for (int r = 0; r < 12; r++) rd_check(7, r, 8'(r * 16 + 8'hA5), "R8");
    wr(7, 12, 8'h5A);
    rd_check(7, 12, 8'h00, "R8");
    rd_check(6, 11, 8'h00, "R8");

    // R4 and R5: increment across 0xFFFF, pair pattern cut after one lane
    setup(2, 8'h01, 8'h18, 16'hFFFE, 8'h7E, 16'd5);
    run(8'h04, "R5", 1'b0);

    // R1: two channels, double-pair and four-lane patterns, both cut mid-pattern
    setup(0, 8'h03, 8'h04, 16'h1000, 8'h01, 16'd6);
    setup(5, 8'h04, 8'h40, 16'h2000, 8'h02, 16'd7);
    run(8'h21, "R1", 1'b0);

    // R2: decrement across 0x0000, fixed, fixed with the down bit set
    setup(1, 8'h12, 8'h22, 16'h0001, 8'h10, 16'd4);
    setup(3, 8'h0D, 8'h30, 16'h5555, 8'h20, 16'd5);
    setup(6, 8'h18, 8'h31, 16'h0100, 8'h40, 16'd3);
    run(8'h4A, "R2", 1'b0);

    // R6 with R9: reverse direction, trigger poked while busy
    setup(4, 8'h87, 8'hF0, 16'h3000, 8'hC0, 16'd9);
    run(8'h10, "R6", 1'b1);

    // R3: zero length moves 65536 bytes
    setup(6, 8'h08, 8'h0A, 16'h4444, 8'h33, 16'h0000);
    run(8'h40, "R3", 1'b0);

    finish_up();
  end

endmodule